// File: doc/BRIEF.md
# CPU Hotplug Register Controller

This block keeps the hotplug bookkeeping for a fixed set of processor slots and exposes all of it to software through a four-word register window. Software picks a slot by writing a selector, then reads that slot's flag byte, acts on it with flag writes, issues commands, and moves values through a 32-bit data word. A second read-only word in the window carries the upper half of 64-bit results.

On the platform side, the block takes plug, unplug-request and unplug-complete pulses, each tagged with a slot index. A hot plug or an unplug request raises a one-cycle event pulse that the platform forwards to the OS. Eject writes from software come out as a slot-tagged eject pulse, and status reports from the OS come out as a pulse carrying the slot, its stored event word and the new status word. Each slot's 64-bit architecture identifier is `ID_BASE + slot * ID_STEP`.

The window has four 32-bit words with byte enables. Word 0 takes selector writes and returns the upper data half on reads. Word 1 holds the flag byte in lane 0 and the command byte in lane 1. Word 2 is the data word. Word 3 reads as zero. Every read returns its data one cycle after the request, and byte lanes that are not enabled read as zero.

Top module: `cpuhp_regctl`

## Requirements
- R1: After reset, slot 0 is present and enabled, and no other slot has any flag set. The selector and the command both reset to 0. The response, event, eject and status-report outputs are all low.
- R2: A flag read (word 1, lane 0) returns bit0 enabled, bit1 insert pending, bit2 remove pending, bit4 firmware-remove and bit5 present. All other bits read 0.
- R3: A flag write acts only on the lowest set bit among bits 1 to 4. Bit1 clears insert pending, bit2 clears remove pending, bit3 ejects the slot and bit4 sets firmware-remove. Higher set bits in the same write have no effect.
- R4: Eject and firmware-remove are ignored for slot 0 and for slots that are not present. An eject clears present, enabled and firmware-remove for the slot, and pulses `eject_valid` with `eject_slot` for one cycle.
- R5: While the selector is N_SLOTS or more, every read returns 0 and writes to words 1 and 2 are dropped. Selector writes are always accepted.
- R6: Command codes are 0 (find next event), 1 (store OS event word), 2 (store OS status word) and 3 (read architecture ID). A command byte of 4 or more leaves the command unchanged.
- R7: Writing command 0 searches the slots for one with insert, remove or firmware-remove set. The search starts at the current selector, includes it, and wraps past the last slot. The selector moves to the first match and stays unchanged when no slot matches.
- R8: Under command 0, a data read returns the selector and a word-0 read returns 0. Under command 3, a data read returns bits 31:0 and a word-0 read returns bits 63:32 of `ID_BASE + slot*ID_STEP`.
- R9: Under command 1, a data write stores the slot's OS event word and emits no report. Under command 2, a data write stores the status word and pulses `ost_valid` for one cycle, with the slot, the stored event word and the written status.
- R10: A plug with `plug_hot` high sets present, enabled and insert pending; a plug with `plug_hot` low sets only present and enabled. An unplug request sets remove pending. An unplug-complete clears present and enabled. Each hot plug and each unplug request gives one `event_pulse` on the cycle after the input; a plug with `plug_hot` low gives none.
- R11: `rsp_valid` is high exactly on the cycle after a read request. Lanes whose byte enable is low read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 2 | Word index within the window |
| req_be | input | 4 | Byte enables, lane 0 is bits 7:0 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| plug_valid | input | 1 | Slot plugged |
| plug_slot | input | IDX_W | Slot of the plug |
| plug_hot | input | 1 | Plug happened at run time |
| unreq_valid | input | 1 | Unplug requested |
| unreq_slot | input | IDX_W | Slot of the request |
| unplug_valid | input | 1 | Unplug completed |
| unplug_slot | input | IDX_W | Slot removed |
| event_pulse | output | 1 | Hotplug event for the OS |
| eject_valid | output | 1 | Software ejected a slot |
| eject_slot | output | IDX_W | Ejected slot |
| ost_valid | output | 1 | OS status report |
| ost_slot | output | IDX_W | Reporting slot |
| ost_event | output | 32 | Stored OS event word |
| ost_status | output | 32 | Reported status word |

## Verification
The assertions assume the inputs stay idle while reset is high: the read-latency and event-cause properties compare outputs with inputs from the previous cycle, and that cycle can be the last reset cycle. The bench keeps every request and platform pulse low until reset has been released for a cycle. It also drives only one platform pulse at a time, so the cause of each event can be identified. Slot indices on the platform inputs always name existing slots.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

  typedef enum logic [1:0] {
    CMD_SCAN    = 2'd0,
    CMD_OST_EV  = 2'd1,
    CMD_OST_ST  = 2'd2,
    CMD_ARCH_ID = 2'd3
  } cmd_e;

  localparam logic [1:0] W_SEL  = 2'd0;
  localparam logic [1:0] W_CTRL = 2'd1;
  localparam logic [1:0] W_DATA = 2'd2;

  function automatic logic [63:0] slot_arch_id(input logic [63:0] base,
                                               input logic [63:0] step,
                                               input logic [31:0] idx);
    return base + ({32'd0, idx} * step);
  endfunction

endpackage

// File: rtl/cpuhp_event_finder.sv
module cpuhp_event_finder #(
  parameter int N_SLOTS = 8,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [N_SLOTS-1:0] pend,
  input  logic [IDX_W-1:0]   start,
  output logic               found,
  output logic [IDX_W-1:0]   hit
);
  // Walk the ring backwards so the nearest slot to start is written last.
  always_comb begin
    found = 1'b0;
    hit   = start;
    for (int k = N_SLOTS - 1; k >= 0; k--) begin
      int j;
      j = int'(start) + k;
      if (j >= N_SLOTS) j = j - N_SLOTS;
      if (pend[IDX_W'(j)]) begin
        found = 1'b1;
        hit   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/cpuhp_slot_bank.sv
module cpuhp_slot_bank #(
  parameter int N_SLOTS = 8,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   op_slot,
  input  logic               op_clr_ins,
  input  logic               op_clr_rem,
  input  logic               op_eject,
  input  logic               op_fw_set,
  input  logic               plug_valid,
  input  logic [IDX_W-1:0]   plug_slot,
  input  logic               plug_hot,
  input  logic               unreq_valid,
  input  logic [IDX_W-1:0]   unreq_slot,
  input  logic               unplug_valid,
  input  logic [IDX_W-1:0]   unplug_slot,
  output logic [N_SLOTS-1:0] present,
  output logic [N_SLOTS-1:0] enabled,
  output logic [N_SLOTS-1:0] ins_pend,
  output logic [N_SLOTS-1:0] rem_pend,
  output logic [N_SLOTS-1:0] fw_rem,
  output logic               raise_evt
);
  logic [N_SLOTS-1:0] hot_hit;
  logic [N_SLOTS-1:0] req_hit;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic pr_q, en_q, in_q, rm_q, fw_q;
    logic op_here, plug_here, req_here, gone_here;

    assign op_here   = (op_slot == IDX_W'(i));
    assign plug_here = plug_valid && (plug_slot == IDX_W'(i));
    assign req_here  = unreq_valid && (unreq_slot == IDX_W'(i));
    assign gone_here = unplug_valid && (unplug_slot == IDX_W'(i));

    // Software actions first; platform inputs in the same cycle take precedence.
    always_ff @(posedge clk) begin
      if (rst) begin
        pr_q <= (i == 0);
        en_q <= (i == 0);
        in_q <= 1'b0;
        rm_q <= 1'b0;
        fw_q <= 1'b0;
      end else begin
        if (op_here) begin
          if (op_clr_ins) in_q <= 1'b0;
          if (op_clr_rem) rm_q <= 1'b0;
          if (op_fw_set)  fw_q <= 1'b1;
          if (op_eject) begin
            pr_q <= 1'b0;
            en_q <= 1'b0;
            fw_q <= 1'b0;
          end
        end
        if (gone_here) begin
          pr_q <= 1'b0;
          en_q <= 1'b0;
        end
        if (plug_here) begin
          pr_q <= 1'b1;
          en_q <= 1'b1;
          if (plug_hot) in_q <= 1'b1;
        end
        if (req_here) rm_q <= 1'b1;
      end
    end

    assign present[i]  = pr_q;
    assign enabled[i]  = en_q;
    assign ins_pend[i] = in_q;
    assign rem_pend[i] = rm_q;
    assign fw_rem[i]   = fw_q;
    assign hot_hit[i]  = plug_here && plug_hot;
    assign req_hit[i]  = req_here;
  end

  assign raise_evt = (|hot_hit) || (|req_hit);
endmodule

// File: rtl/cpuhp_ost_store.sv
module cpuhp_ost_store #(
  parameter int N_SLOTS = 8,
  parameter int DW = 32,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int NB = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] slot,
  input  logic             we_event,
  input  logic             we_status,
  input  logic [NB-1:0]    be,
  input  logic [DW-1:0]    wdata,
  output logic             ost_valid,
  output logic [IDX_W-1:0] ost_slot,
  output logic [DW-1:0]    ost_event,
  output logic [DW-1:0]    ost_status
);
  logic [DW-1:0] ev_mem [N_SLOTS];
  logic [DW-1:0] st_mem [N_SLOTS];
  logic [DW-1:0] st_merged;

  always_comb begin
    st_merged = st_mem[slot];
    for (int b = 0; b < NB; b++)
      if (be[b]) st_merged[8*b +: 8] = wdata[8*b +: 8];
  end

  // Byte-lane writes, one port per array.
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we_event && be[b])  ev_mem[slot][8*b +: 8] <= wdata[8*b +: 8];
      if (we_status && be[b]) st_mem[slot][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ost_valid  <= 1'b0;
      ost_slot   <= '0;
      ost_event  <= '0;
      ost_status <= '0;
    end else begin
      ost_valid <= we_status;
      if (we_status) begin
        ost_slot   <= slot;
        ost_event  <= ev_mem[slot];
        ost_status <= st_merged;
      end
    end
  end
endmodule

// File: rtl/cpuhp_regctl.sv
module cpuhp_regctl #(
  parameter int          N_SLOTS = 8,
  parameter logic [63:0] ID_BASE = 64'h0000_00A5_0000_0100,
  parameter logic [63:0] ID_STEP = 64'h0000_0001_0000_0002,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_word,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  input  logic             plug_valid,
  input  logic [IDX_W-1:0] plug_slot,
  input  logic             plug_hot,
  input  logic             unreq_valid,
  input  logic [IDX_W-1:0] unreq_slot,
  input  logic             unplug_valid,
  input  logic [IDX_W-1:0] unplug_slot,
  output logic             event_pulse,
  output logic             eject_valid,
  output logic [IDX_W-1:0] eject_slot,
  output logic             ost_valid,
  output logic [IDX_W-1:0] ost_slot,
  output logic [31:0]      ost_event,
  output logic [31:0]      ost_status
);
  import cpuhp_pkg::*;

  logic [31:0]      sel_q;
  cmd_e             cmd_q;
  logic             sel_ok;
  logic [IDX_W-1:0] sidx;
  logic             wr, rd;
  logic [7:0]       fbyte, cbyte;
  logic             flag_wr, cmd_wr, data_wr;
  logic             guard_ok;
  logic             op_clr_ins, op_clr_rem, op_eject, op_fw_set;
  logic [N_SLOTS-1:0] present, enabled, ins_pend, rem_pend, fw_rem;
  logic             raise_evt;
  logic             scan_found;
  logic [IDX_W-1:0] scan_hit;
  logic [63:0]      cur_id;
  logic [7:0]       flag_view;
  logic [31:0]      rd_word, rd_masked;

  assign sel_ok = (sel_q < 32'(N_SLOTS));
  assign sidx   = sel_q[IDX_W-1:0];
  assign wr     = req_valid && req_write;
  assign rd     = req_valid && !req_write;
  assign fbyte  = req_wdata[7:0];
  assign cbyte  = req_wdata[15:8];

  assign flag_wr = wr && sel_ok && (req_word == W_CTRL) && req_be[0];
  assign cmd_wr  = wr && sel_ok && (req_word == W_CTRL) && req_be[1];
  assign data_wr = wr && sel_ok && (req_word == W_DATA) && (|req_be);

  // Lowest set action bit wins; eject and firmware-remove need a present non-boot slot.
  assign guard_ok   = present[sidx] && (sidx != '0);
  assign op_clr_ins = flag_wr && fbyte[1];
  assign op_clr_rem = flag_wr && (fbyte[2:1] == 2'b10);
  assign op_eject   = flag_wr && (fbyte[3:1] == 3'b100) && guard_ok;
  assign op_fw_set  = flag_wr && (fbyte[4:1] == 4'b1000) && guard_ok;

  cpuhp_slot_bank #(.N_SLOTS(N_SLOTS)) u_bank (
    .clk(clk), .rst(rst),
    .op_slot(sidx), .op_clr_ins(op_clr_ins), .op_clr_rem(op_clr_rem),
    .op_eject(op_eject), .op_fw_set(op_fw_set),
    .plug_valid(plug_valid), .plug_slot(plug_slot), .plug_hot(plug_hot),
    .unreq_valid(unreq_valid), .unreq_slot(unreq_slot),
    .unplug_valid(unplug_valid), .unplug_slot(unplug_slot),
    .present(present), .enabled(enabled), .ins_pend(ins_pend),
    .rem_pend(rem_pend), .fw_rem(fw_rem), .raise_evt(raise_evt)
  );

  cpuhp_event_finder #(.N_SLOTS(N_SLOTS)) u_find (
    .pend(ins_pend | rem_pend | fw_rem),
    .start(sidx),
    .found(scan_found),
    .hit(scan_hit)
  );

  cpuhp_ost_store #(.N_SLOTS(N_SLOTS), .DW(32)) u_ost (
    .clk(clk), .rst(rst), .slot(sidx),
    .we_event(data_wr && (cmd_q == CMD_OST_EV)),
    .we_status(data_wr && (cmd_q == CMD_OST_ST)),
    .be(req_be), .wdata(req_wdata),
    .ost_valid(ost_valid), .ost_slot(ost_slot),
    .ost_event(ost_event), .ost_status(ost_status)
  );

  // Selector and command registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cmd_q <= CMD_SCAN;
    end else begin
      if (wr && (req_word == W_SEL)) begin
        for (int b = 0; b < 4; b++)
          if (req_be[b]) sel_q[8*b +: 8] <= req_wdata[8*b +: 8];
      end
      if (cmd_wr && (cbyte < 8'd4)) begin
        cmd_q <= cmd_e'(cbyte[1:0]);
        if ((cbyte[1:0] == 2'd0) && scan_found)
          sel_q <= {{(32-IDX_W){1'b0}}, scan_hit};
      end
    end
  end

  assign cur_id    = slot_arch_id(ID_BASE, ID_STEP, {{(32-IDX_W){1'b0}}, sidx});
  assign flag_view = {2'b00, present[sidx], fw_rem[sidx], 1'b0,
                      rem_pend[sidx], ins_pend[sidx], enabled[sidx]};

  always_comb begin
    rd_word = '0;
    case (req_word)
      W_SEL:   rd_word = (cmd_q == CMD_ARCH_ID) ? cur_id[63:32] : 32'd0;
      W_CTRL:  rd_word = {24'd0, flag_view};
      W_DATA: begin
        if (cmd_q == CMD_SCAN)         rd_word = sel_q;
        else if (cmd_q == CMD_ARCH_ID) rd_word = cur_id[31:0];
      end
      default: rd_word = '0;
    endcase
    rd_masked = '0;
    for (int b = 0; b < 4; b++)
      if (req_be[b]) rd_masked[8*b +: 8] = rd_word[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      event_pulse <= 1'b0;
      eject_valid <= 1'b0;
      eject_slot  <= '0;
    end else begin
      rsp_valid   <= rd;
      rsp_data    <= (rd && sel_ok) ? rd_masked : 32'd0;
      event_pulse <= raise_evt;
      eject_valid <= op_eject;
      if (op_eject) eject_slot <= sidx;
    end
  end
endmodule

// File: rtl/cpuhp_regctl_chk.sv
module cpuhp_regctl_chk #(
  parameter int N_SLOTS = 8,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [1:0]       req_word,
  input logic [3:0]       req_be,
  input logic [7:0]       cmd_byte,
  input logic             rsp_valid,
  input logic [31:0]      rsp_data,
  input logic             plug_valid,
  input logic             plug_hot,
  input logic             unreq_valid,
  input logic             event_pulse,
  input logic             eject_valid,
  input logic [IDX_W-1:0] eject_slot,
  input logic             ost_valid,
  input logic [31:0]      sel_q,
  input logic [1:0]       cmd_q
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid && !req_write)); // R11

  AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    event_pulse |-> $past((plug_valid && plug_hot) || unreq_valid)); // R10

  AST_NO_BOOT_EJECT: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> (eject_slot != '0)); // R4

  AST_EJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> $past(req_valid && req_write && req_word == 2'd1 && req_be[0])); // R3

  AST_OST_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    ost_valid |-> $past(req_valid && req_write && req_word == 2'd2 && cmd_q == 2'd2)); // R9

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(sel_q >= 32'(N_SLOTS))) |-> (rsp_data == 32'd0)); // R5

  AST_BAD_CMD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_write && req_word == 2'd1 && req_be[1] && cmd_byte >= 8'd4)
      |-> $stable(cmd_q)); // R6
endmodule

bind cpuhp_regctl cpuhp_regctl_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_word(req_word), .req_be(req_be), .cmd_byte(req_wdata[15:8]),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .plug_valid(plug_valid),
  .plug_hot(plug_hot), .unreq_valid(unreq_valid), .event_pulse(event_pulse),
  .eject_valid(eject_valid), .eject_slot(eject_slot), .ost_valid(ost_valid),
  .sel_q(sel_q), .cmd_q(cmd_q)
);

// File: tb/cpuhp_regctl_bench.sv
module cpuhp_regctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_word = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic plug_valid = 1'b0, plug_hot = 1'b0, unreq_valid = 1'b0, unplug_valid = 1'b0;
  logic [IW-1:0] plug_slot = '0, unreq_slot = '0, unplug_slot = '0;
  logic event_pulse, eject_valid, ost_valid;
  logic [IW-1:0] eject_slot, ost_slot;
  logic [31:0] ost_event, ost_status;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic cap_ost, cap_ej, cap_evt;
  logic [IW-1:0] cap_ejs, cap_osts;
  logic [31:0] cap_ev, cap_st, got;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuhp_regctl #(.N_SLOTS(N)) u_cpuhp_regctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .plug_valid(plug_valid), .plug_slot(plug_slot), .plug_hot(plug_hot),
    .unreq_valid(unreq_valid), .unreq_slot(unreq_slot),
    .unplug_valid(unplug_valid), .unplug_slot(unplug_slot),
    .event_pulse(event_pulse), .eject_valid(eject_valid), .eject_slot(eject_slot),
    .ost_valid(ost_valid), .ost_slot(ost_slot), .ost_event(ost_event),
    .ost_status(ost_status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    cap_ost = ost_valid; cap_osts = ost_slot; cap_ev = ost_event; cap_st = ost_status;
    cap_ej = eject_valid; cap_ejs = eject_slot;
  endtask

  task automatic bus_rd(input logic [1:0] w, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = w; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  task automatic flags_of(input int s, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    bus_wr(2'd0, 4'hF, 32'(s));
    bus_rd(2'd1, 4'h1, v);
    check(tag, v, exp);
  endtask

  task automatic do_plug(input int s, input logic hot);
    @(negedge clk); plug_valid = 1'b1; plug_slot = IW'(s); plug_hot = hot;
    @(negedge clk); plug_valid = 1'b0; cap_evt = event_pulse;
  endtask

  task automatic do_unreq(input int s);
    @(negedge clk); unreq_valid = 1'b1; unreq_slot = IW'(s);
    @(negedge clk); unreq_valid = 1'b0; cap_evt = event_pulse;
  endtask

  task automatic do_unplug(input int s);
    @(negedge clk); unplug_valid = 1'b1; unplug_slot = IW'(s);
    @(negedge clk); unplug_valid = 1'b0;
  endtask

  // {write, word[1:0], be[3:0], wdata[31:0], expected[31:0]}
  localparam int NV = 16;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 2'd1, 4'h1, 32'h0, 32'h0000_0021},  // R1 R2 slot 0 flags
    {1'b1, 2'd0, 4'hF, 32'd3, 32'h0},          // select slot 3
    {1'b0, 2'd1, 4'h1, 32'h0, 32'h0000_0000},  // R1 empty slot
    {1'b1, 2'd1, 4'h2, 32'h0000_0300, 32'h0},  // cmd 3
    {1'b0, 2'd2, 4'hF, 32'h0, 32'h0000_0106},  // R8 id low
    {1'b0, 2'd0, 4'hF, 32'h0, 32'h0000_00A8},  // R8 id high
    {1'b0, 2'd2, 4'h3, 32'h0, 32'h0000_0106},  // R11 lanes
    {1'b1, 2'd1, 4'h2, 32'h0000_0700, 32'h0},  // bad cmd 7
    {1'b0, 2'd2, 4'hF, 32'h0, 32'h0000_0106},  // R6 still cmd 3
    {1'b1, 2'd1, 4'h2, 32'h0000_0000, 32'h0},  // cmd 0, nothing pending
    {1'b0, 2'd2, 4'hF, 32'h0, 32'h0000_0003},  // R7 R8 selector kept
    {1'b0, 2'd0, 4'hF, 32'h0, 32'h0000_0000},  // R8 upper zero
    {1'b1, 2'd0, 4'hF, 32'd9, 32'h0},          // out of range
    {1'b0, 2'd1, 4'h1, 32'h0, 32'h0000_0000},  // R5 flags zero
    {1'b0, 2'd2, 4'hF, 32'h0, 32'h0000_0000},  // R5 data zero
    {1'b1, 2'd0, 4'hF, 32'd0, 32'h0}           // R5 selector writable
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 event reset", {31'd0, event_pulse}, 32'd0);
    check("R1 eject reset", {31'd0, eject_valid}, 32'd0);
    check("R1 ost reset", {31'd0, ost_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) bus_wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][69:68], VEC[i][67:64], v);
        check($sformatf("R8 vector %0d", i), v, VEC[i][31:0]);
      end
    end
    flags_of(0, 32'h21, "R5 slot 0 after reselect");

    do_plug(5, 1'b1);
    check("R10 hot plug event", {31'd0, cap_evt}, 32'd1);
    flags_of(5, 32'h23, "R10 hot plug flags");
    do_unreq(2);
    check("R10 unplug request event", {31'd0, cap_evt}, 32'd1);
    flags_of(2, 32'h04, "R10 remove pending");

    bus_wr(2'd0, 4'hF, 32'd6);
    bus_wr(2'd1, 4'h2, 32'h0000_0000);
    bus_rd(2'd2, 4'hF, v);
    check("R7 wrap search", v, 32'd2);
    bus_wr(2'd1, 4'h2, 32'h0000_0000);
    bus_rd(2'd2, 4'hF, v);
    check("R7 start inclusive", v, 32'd2);

    bus_wr(2'd1, 4'h1, 32'h04);
    bus_rd(2'd1, 4'h1, v);
    check("R3 clear remove", v, 32'h00);
    bus_wr(2'd0, 4'hF, 32'd5);
    bus_wr(2'd1, 4'h1, 32'h1E);
    bus_rd(2'd1, 4'h1, v);
    check("R3 only insert cleared", v, 32'h21);
    bus_wr(2'd1, 4'h1, 32'h10);
    bus_rd(2'd1, 4'h1, v);
    check("R4 firmware remove set", v, 32'h31);
    bus_wr(2'd0, 4'hF, 32'd6);
    bus_wr(2'd1, 4'h2, 32'h0000_0000);
    bus_rd(2'd2, 4'hF, v);
    check("R7 firmware remove found", v, 32'd5);
    bus_wr(2'd1, 4'h1, 32'h18);
    check("R3 eject wins over fw", {31'd0, cap_ej}, 32'd1);
    check("R4 eject slot", {29'd0, cap_ejs}, 32'd5);
    bus_rd(2'd1, 4'h1, v);
    check("R4 eject clears", v, 32'h00);

    bus_wr(2'd0, 4'hF, 32'd0);
    bus_wr(2'd1, 4'h1, 32'h08);
    check("R4 boot eject ignored", {31'd0, cap_ej}, 32'd0);
    bus_wr(2'd1, 4'h1, 32'h10);
    bus_rd(2'd1, 4'h1, v);
    check("R4 boot slot unchanged", v, 32'h21);
    flags_of(6, 32'h00, "R1 slot 6 empty");
    bus_wr(2'd1, 4'h1, 32'h10);
    bus_rd(2'd1, 4'h1, v);
    check("R4 absent fw ignored", v, 32'h00);

    bus_wr(2'd0, 4'hF, 32'd9);
    bus_wr(2'd1, 4'h2, 32'h0000_0300);
    bus_wr(2'd0, 4'hF, 32'd3);
    bus_rd(2'd2, 4'hF, v);
    check("R5 command write dropped", v, 32'd3);

    bus_wr(2'd0, 4'hF, 32'd4);
    bus_wr(2'd1, 4'h2, 32'h0000_0100);
    bus_wr(2'd2, 4'hF, 32'hDEAD_0001);
    check("R9 event write no report", {31'd0, cap_ost}, 32'd0);
    bus_wr(2'd1, 4'h2, 32'h0000_0200);
    bus_wr(2'd2, 4'hF, 32'h0000_BEEF);
    check("R9 report pulse", {31'd0, cap_ost}, 32'd1);
    check("R9 report slot", {29'd0, cap_osts}, 32'd4);
    check("R9 report event", cap_ev, 32'hDEAD_0001);
    check("R9 report status", cap_st, 32'h0000_BEEF);

    do_plug(7, 1'b0);
    check("R10 cold plug no event", {31'd0, cap_evt}, 32'd0);
    flags_of(7, 32'h21, "R10 cold plug flags");
    do_unplug(7);
    bus_rd(2'd1, 4'h1, v);
    check("R10 unplug clears", v, 32'h00);
    do_plug(7, 1'b1);
    do_unplug(7);
    bus_rd(2'd1, 4'h1, v);
    check("R10 insert survives unplug", v, 32'h02);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule